// File: doc/BRIEF.md
# Interleaved Half-Rate Shift Register

This block is a serial-in, serial-out delay line of even length N that produces the same output stream as a plain N-stage shift register, while each storage flip-flop is written at most once every two input clocks. The N positions are split between two banks of N/2 flip-flops. One bank holds the newest bit and every second older bit, and the other holds the bits in between. A one-bit phase divider enables the two banks on alternate cycles. The serial output comes from a phase-controlled multiplexer that always picks the bank holding the oldest bit.

A parallel load puts an N-bit word into the line in one cycle, as a conventional register would do. The bank due to capture on the load cycle takes the even-numbered bits of the word. The odd-numbered bits wait in a small staging register and go into the other bank on its next turn. While they wait, the staging register supplies the output bit.

Top module: `interleaved_sreg`

## Requirements
- R1: A synchronous active-low reset clears both banks, the staging flag and the phase divider. The serial output is 0 in the first cycle after reset, and the next cycle captures into the bank of even positions.
- R2: With no load, a bit sampled on the serial input at clock edge t appears on the serial output after edge t+N-1. It stays there until edge t+N.
- R3: The phase divider toggles on every clock after reset. A load lands the same way whichever phase it meets, so the same word and the same following input give the same output stream.
- R4: A storage bit in either bank changes state at most once in any two consecutive clock cycles.
- R5: After a load of word W, bit 0 being the first position, the serial output shows W[N-1], W[N-2], ..., W[0] on the following N cycles. Serial input bits follow after that.
- R6: On back-to-back loads the newer word wins. The output after the second load begins with that word's bit N-1, and no bit of the first word appears.
- R7: The serial input bit sampled on a load cycle is discarded and never reaches the output.
- R8: For any mix of serial input bits and loads, the serial output matches a conventional single-chain N-stage shift register cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; every register samples on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Parallel load strobe, takes priority over shifting |
| ld_word | input | N | Word to load; bit k goes to line position k (0 = newest) |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output (line position N-1) |

## Verification
The bench builds the line with N = 8, so each bank is four bits deep and the staging register is four bits wide. A loaded word drains in eight cycles. That keeps loads on both divider phases, back-to-back loads, and loads that land while the staging register is still full within reach of short directed sequences. A long random run against a behavioural single-chain model then reaches every order of load, deferred bank fill and plain shift.

// File: rtl/isr_pkg.sv
// Shared definitions for the interleaved shift register.
// Assumes nothing beyond being compiled before the modules that import it.
package isr_pkg;

    // Which bank the next rising clock edge writes.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } isr_phase_e;

    // Bank update source when the bank's phase comes up.
    typedef enum logic [1:0] {
        SRC_SHIFT = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_DEFER = 2'd2
    } isr_src_e;

endpackage

// File: rtl/isr_phase_div.sv
// Divide-by-two phase generator.
// Produces the half-rate phase that decides which bank captures on the next
// edge. Reset forces PH_EVEN so bank selection is known from the first cycle.
module isr_phase_div
    import isr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output isr_phase_e phase
);

    isr_phase_e phase_q;

    // Toggle the phase on every input clock, park at PH_EVEN in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_EVEN;
        end else begin
            phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/isr_half_chain.sv
// One half-length bank of the interleaved line.
// Bit 0 holds the newest bit the bank owns. The bank only writes when cap_en
// is high, which happens once every two input clocks. Assumes DEPTH >= 2.
module isr_half_chain
    import isr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  isr_src_e         src,
    input  logic             din,
    input  logic [DEPTH-1:0] ld_bits,
    input  logic [DEPTH-2:0] defer_bits,
    output logic [DEPTH-1:0] q
);

    logic [DEPTH-1:0] q_r;
    logic [DEPTH-1:0] q_next;

    // Choose the next bank contents from the load word, the staged word or the shift path.
    always_comb begin
        unique case (src)
            SRC_LOAD:  q_next = ld_bits;
            SRC_DEFER: q_next = {defer_bits, din};
            default:   q_next = {q_r[DEPTH-2:0], din};
        endcase
    end

    // Write the bank only on its own phase so each bit toggles at half rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (cap_en) begin
            q_r <= q_next;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/isr_load_stage.sv
// Staging register for the half of a load word that cannot be written on the
// load cycle. It holds the odd-position bits for one cycle and raises
// pend_valid. During that cycle its top bit (word bit N-1) drives the output.
// A new load while staged data is pending replaces it.
module isr_load_stage #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [DEPTH-1:0] odd_bits,
    output logic [DEPTH-1:0] pend_bits,
    output logic             pend_valid
);

    logic [DEPTH-1:0] pend_q;
    logic             valid_q;

    // Capture the odd half on a load; keep the data, it is only read while valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (ld_en) begin
            pend_q <= odd_bits;
        end
    end

    // Flag staged data for exactly the cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= ld_en;
        end
    end

    assign pend_bits  = pend_q;
    assign pend_valid = valid_q;

endmodule

// File: rtl/isr_out_mux.sv
// Output recombiner. The bank due to capture next holds the oldest bit, so the
// phase selects it. While a split load is pending, the staged top bit is used.
module isr_out_mux
    import isr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  isr_phase_e       phase,
    input  logic             pend_valid,
    input  logic             pend_top,
    input  logic [DEPTH-1:0] even_q,
    input  logic [DEPTH-1:0] odd_q,
    output logic             sout
);

    // Pick the oldest bit among the staging register and the two banks.
    always_comb begin
        if (pend_valid) begin
            sout = pend_top;
        end else if (phase == PH_ODD) begin
            sout = odd_q[DEPTH-1];
        end else begin
            sout = even_q[DEPTH-1];
        end
    end

endmodule

// File: rtl/interleaved_sreg.sv
// Interleaved half-rate shift register, top level.
// Behaves as an N-stage serial shift register with parallel load, with the
// positions spread over two banks written on alternate clocks. N must be even
// and at least 4.
module interleaved_sreg
    import isr_pkg::*;
#(
    parameter int N = 288
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic [N-1:0] ld_word,
    input  logic         sin,
    output logic         sout
);

    localparam int H = N / 2;

    if ((N % 2) != 0 || N < 4) begin : g_bad_len
        $error("interleaved_sreg: N must be even and at least 4");
    end

    isr_phase_e phase;
    logic       cap_odd;
    logic [H-1:0] ld_even;
    logic [H-1:0] ld_odd;
    logic [H-1:0] even_q;
    logic [H-1:0] odd_q;
    logic [H-1:0] pend_bits;
    logic         pend_valid;
    isr_src_e     src;

    // Split the load word by position parity.
    for (genvar j = 0; j < H; j++) begin : g_split
        assign ld_even[j] = ld_word[2*j];
        assign ld_odd[j]  = ld_word[2*j+1];
    end

    assign cap_odd = (phase == PH_ODD);

    // Load beats a pending deferred fill, which beats a plain shift.
    always_comb begin
        if (ld_en) begin
            src = SRC_LOAD;
        end else if (pend_valid) begin
            src = SRC_DEFER;
        end else begin
            src = SRC_SHIFT;
        end
    end

    isr_phase_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    isr_load_stage #(.DEPTH(H)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .odd_bits   (ld_odd),
        .pend_bits  (pend_bits),
        .pend_valid (pend_valid)
    );

    isr_half_chain #(.DEPTH(H)) u_bank_even (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (!cap_odd),
        .src        (src),
        .din        (sin),
        .ld_bits    (ld_even),
        .defer_bits (pend_bits[H-2:0]),
        .q          (even_q)
    );

    isr_half_chain #(.DEPTH(H)) u_bank_odd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_odd),
        .src        (src),
        .din        (sin),
        .ld_bits    (ld_even),
        .defer_bits (pend_bits[H-2:0]),
        .q          (odd_q)
    );

    isr_out_mux #(.DEPTH(H)) u_mux (
        .phase      (phase),
        .pend_valid (pend_valid),
        .pend_top   (pend_bits[H-1]),
        .even_q     (even_q),
        .odd_q      (odd_q),
        .sout       (sout)
    );

endmodule

// File: rtl/isr_checks.sv
// Property checker for interleaved_sreg, attached by bind below.
// Watches the ports, the phase, both banks and the staging flag.
module isr_checks #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_en,
    input logic [N-1:0] ld_word,
    input logic         sout,
    input logic         cap_odd,
    input logic [N/2-1:0] even_q,
    input logic [N/2-1:0] odd_q,
    input logic         pend_valid
);

    // R1: first cycle out of reset shows a cleared output
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sout == 1'b0));

    // R3: the divider flips every cycle once running
    a_r3_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cap_odd != $past(cap_odd)));

    // R4: even bank is quiet on the odd bank's turn
    a_r4_even_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cap_odd |=> $stable(even_q));

    // R4: odd bank is quiet on the even bank's turn
    a_r4_odd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_odd |=> $stable(odd_q));

    // R5: the word's top bit is on the output right after a load
    a_r5_load_head: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (sout == $past(ld_word[N-1])));

    // R8: a deferred fill lasts one cycle unless a new load arrives
    a_r8_pend_once: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !ld_en) |=> !pend_valid);

endmodule

bind interleaved_sreg isr_checks #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_word    (ld_word),
    .sout       (sout),
    .cap_odd    (cap_odd),
    .even_q     (even_q),
    .odd_q      (odd_q),
    .pend_valid (pend_valid)
);

// File: tb/sim_interleaved_sreg.sv
// Self-checking bench: vector table, random run against a plain shift
// register model, then directed corner cases.
module sim_interleaved_sreg;

    localparam int N        = 8;
    localparam int CLK_HALF = 10;
    localparam int NVEC     = 24;

    // {ld_en, sin, ld_word}
    localparam logic [N+1:0] VEC [NVEC] = '{
        10'b0_1_00000000, 10'b0_0_00000000, 10'b0_1_00000000, 10'b0_1_00000000,
        10'b1_0_10100101, 10'b0_0_00000000, 10'b0_1_00000000, 10'b0_0_00000000,
        10'b0_1_00000000, 10'b1_1_01111110, 10'b1_0_11000011, 10'b0_1_00000000,
        10'b0_1_00000000, 10'b0_0_00000000, 10'b0_0_00000000, 10'b0_1_00000000,
        10'b0_0_00000000, 10'b0_1_00000000, 10'b1_1_00010001, 10'b0_0_00000000,
        10'b1_0_11111111, 10'b0_0_00000000, 10'b0_0_00000000, 10'b0_1_00000000
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_en = 1'b0;
    logic         sin = 1'b0;
    logic [N-1:0] ld_word = '0;
    logic         sout;
    logic [N-1:0] ref_q = '0;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #CLK_HALF clk = ~clk;

    interleaved_sreg #(.N(N)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_word (ld_word),
        .sin     (sin),
        .sout    (sout)
    );

    task automatic check(input string tag, input logic exp);
        n_vec++;
        if (sout !== exp) begin
            n_bad++;
            $display("FAIL %s: sout=%b expected %b at %0t", tag, sout, exp, $time);
        end
    endtask

    // Drive one cycle from a falling edge, advance the model, compare at the next falling edge.
    task automatic cycle(input logic l, input logic d, input logic [N-1:0] w, input string tag);
        ld_en   = l;
        sin     = d;
        ld_word = w;
        @(posedge clk);
        if (l) ref_q = w;
        else   ref_q = {ref_q[N-2:0], d};
        @(negedge clk);
        check(tag, ref_q[N-1]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ld_en = 1'b0;
        sin   = 1'b0;
        @(posedge clk);
        @(posedge clk);
        ref_q = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset output", 1'b0);
    endtask

    // Load w, then drain it with sin held at fill; expected bits come from w directly.
    task automatic load_and_drain(input logic [N-1:0] w, input logic fill, input string tag);
        cycle(1'b1, ~fill, w, tag);
        for (int k = 0; k < N; k++) begin
            check(tag, w[N-1-k]);
            cycle(1'b0, fill, '0, tag);
        end
        check(tag, fill);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R8: table walk
        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][N+1], VEC[i][N], VEC[i][N-1:0], "R8 table");
        end

        // R2: a lone 1 takes N-1 further edges to reach the output
        do_reset();
        cycle(1'b0, 1'b1, '0, "R2 lone bit");
        for (int k = 0; k < N - 2; k++) begin
            cycle(1'b0, 1'b0, '0, "R2 lone bit");
            check("R2 early", 1'b0);
        end
        cycle(1'b0, 1'b0, '0, "R2 lone bit");
        check("R2 arrival", 1'b1);
        cycle(1'b0, 1'b0, '0, "R2 lone bit");
        check("R2 departure", 1'b0);

        // R5 / R3: same load on even phase, then on odd phase
        do_reset();
        load_and_drain(8'b1011_0100, 1'b1, "R5 even-phase load");
        do_reset();
        cycle(1'b0, 1'b0, '0, "R3 phase shift");
        load_and_drain(8'b1011_0100, 1'b1, "R3 odd-phase load");

        // R6: back-to-back loads, the second wins
        do_reset();
        cycle(1'b1, 1'b0, 8'b1111_1111, "R6 first load");
        load_and_drain(8'b0100_1001, 1'b0, "R6 second load");

        // R7: serial bit on the load cycle is dropped
        do_reset();
        cycle(1'b1, 1'b1, 8'h00, "R7 load with sin=1");
        for (int k = 0; k < N + 2; k++) begin
            cycle(1'b0, 1'b0, '0, "R7 dropped bit");
            check("R7 no leak", 1'b0);
        end

        // R4: full-toggle pattern through both banks
        for (int k = 0; k < 40; k++) begin
            cycle(1'b0, k[0], '0, "R4 alternating");
        end

        // R8: random mix of shifts and loads
        for (int k = 0; k < 3000; k++) begin
            cycle(($urandom % 6) == 0, 1'($urandom), N'($urandom), "R8 random");
        end

        // R1: reset in mid-stream clears everything
        cycle(1'b1, 1'b0, 8'hFF, "R1 pre-reset");
        do_reset();
        for (int k = 0; k < N - 1; k++) begin
            cycle(1'b0, 1'b1, '0, "R1 cleared line");
            check("R1 zeros", 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R8: run state hung, expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule